// File: doc/BRIEF.md
# Register-Pair Arithmetic and Logic Unit (16-bit)

This block holds a 16-bit register pair and a seven-bit flag register. Each enabled clock edge combines the pair with a 16-bit operand under a 3-bit operation select. The result is written back into the pair, and the flags are updated together with it. The unit provides add, add-with-carry, subtract, subtract-with-borrow, AND, XOR and OR. A spare select code loads the operand straight into the pair, so a sequencer can seed the pair without disturbing the flags.

Every operation writes only the flags it defines. All other flag bits keep their stored value. The add, add-with-carry and subtract operations keep the half-carry flag unchanged. Only subtract-with-borrow computes a half-carry, and it takes it from bit 11. Add-with-carry folds the incoming carry into the operand, wrapping at 16 bits, before a plain add. Subtract-with-borrow instead widens the adjusted subtrahend to 17 bits, so that operand 0xFFFF with carry still produces a borrow.

Top module: `pair_alu16`

## Requirements
- R1: An asynchronous active-low reset clears the pair and all flags to zero.
- R2: The flag vector is {S,Z,H,X,V,N,C}, with S at bit 6 and C at bit 0. The select codes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 load. Load copies the operand into the pair and leaves every flag unchanged.
- R3: While the enable is low, the pair and the flags hold their values whatever the select and operand are.
- R4: Add writes the 16-bit sum and sets N=0. C and X are both set to the carry out of bit 15. V is set to the carry out of bit 15 XOR the carry into bit 15. S is set from result bit 15, and Z is set when the result is zero.
- R5: Add-with-carry first adds C to the operand modulo 2^16, then behaves exactly as add. Operand 0xFFFF with C=1 therefore adds zero and produces no carry.
- R6: Subtract writes pair minus operand and sets N=1. C is set to the unsigned borrow. X is set when a borrow occurs and is otherwise unchanged. V is set to signed 16-bit overflow. S and Z are set from the result.
- R7: Subtract-with-borrow subtracts operand+C, computed in 17 bits, and sets N=1. H is set when the pair's low 12 bits are less than the low 12 bits of operand+C. C is set to the unsigned borrow against operand+C. V is set to signed overflow of pair-operand-C. S and Z are set from the result. X is unchanged.
- R8: AND writes pair AND operand. It sets H=1 and clears X, N and C. S and Z are set from the result, and V is unchanged.
- R9: XOR and OR write their bitwise result. They clear H, X, N and C. S and Z are set from the result, and V is unchanged.
- R10: Add, add-with-carry and subtract leave H unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Update the pair and flags on this edge |
| op | input | 3 | Operation select |
| operand | input | 16 | Second operand |
| pair_q | output | 16 | Register pair |
| flags_q | output | 7 | Flags {S,Z,H,X,V,N,C} |

## Verification
The bench runs a chained vector sequence that targets the awkward carry cases. One is add-with-carry on 0xFFFF with carry set: a design that does not wrap the operand would report a carry and a non-zero flag set. Another is subtract-with-borrow on 0xFFFF with carry set: a design that lets the subtrahend wrap would miss the borrow. Further cases cover 0x8000 minus 0x7FFF with borrow, where the signed overflow lands on a zero result, and a 12-bit half-borrow. The sequence also checks that X stays set across a subtract without borrow, and that H survives an add. A design that clears these flags instead of keeping them fails those rows.

// File: rtl/pair_alu16.sv
module pair_alu16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [2:0]   op,
  input  logic [W-1:0] operand,
  output logic [W-1:0] pair_q,
  output logic [6:0]   flags_q
);
  localparam int HB = W - 4;
  localparam int FS = 6, FZ = 5, FH = 4, FX = 3, FV = 2, FN = 1, FC = 0;
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBC = 3'd3,
                         OP_AND = 3'd4, OP_XOR = 3'd5, OP_OR = 3'd6, OP_LD = 3'd7;

  logic         cin;
  logic [W-1:0] add_b;
  logic [W:0]   add_sum;
  logic         add_c_msb;
  logic [W:0]   sub_b;
  logic [W:0]   diff;
  logic         borrow;
  logic [W+1:0] sdiff;
  logic         sub_ov;
  logic [W-1:0] res;
  logic [6:0]   nf;

  assign cin       = flags_q[FC];
  assign add_b     = (op == OP_ADC) ? operand + W'(cin) : operand;
  assign add_sum   = {1'b0, pair_q} + {1'b0, add_b};
  assign add_c_msb = pair_q[W-1] ^ add_b[W-1] ^ add_sum[W-1];

  assign sub_b  = {1'b0, operand} + (W+1)'((op == OP_SBC) && cin);
  assign diff   = {1'b0, pair_q} - sub_b;
  assign borrow = {1'b0, pair_q} < sub_b;
  assign sdiff  = {{2{pair_q[W-1]}}, pair_q} - {{2{operand[W-1]}}, operand}
                  - (W+2)'((op == OP_SBC) && cin);
  assign sub_ov = (sdiff[W+1] != sdiff[W-1]) || (sdiff[W] != sdiff[W-1]);

  always_comb begin
    nf  = flags_q;
    res = pair_q;
    case (op)
      OP_ADD, OP_ADC: begin
        res    = add_sum[W-1:0];
        nf[FC] = add_sum[W];
        nf[FX] = add_sum[W];
        nf[FV] = add_sum[W] ^ add_c_msb;
        nf[FN] = 1'b0;
      end
      OP_SUB: begin
        res    = diff[W-1:0];
        nf[FC] = borrow;
        nf[FX] = flags_q[FX] | borrow;
        nf[FV] = sub_ov;
        nf[FN] = 1'b1;
      end
      OP_SBC: begin
        res    = diff[W-1:0];
        nf[FC] = borrow;
        nf[FH] = pair_q[HB-1:0] < sub_b[HB-1:0];
        nf[FV] = sub_ov;
        nf[FN] = 1'b1;
      end
      OP_AND: begin
        res    = pair_q & operand;
        nf[FH] = 1'b1;
        nf[FX] = 1'b0;
        nf[FN] = 1'b0;
        nf[FC] = 1'b0;
      end
      OP_XOR, OP_OR: begin
        res    = (op == OP_XOR) ? (pair_q ^ operand) : (pair_q | operand);
        nf[FH] = 1'b0;
        nf[FX] = 1'b0;
        nf[FN] = 1'b0;
        nf[FC] = 1'b0;
      end
      default: res = operand;
    endcase
    if (op != OP_LD) begin
      nf[FS] = res[W-1];
      nf[FZ] = (res == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q  <= '0;
      flags_q <= '0;
    end else if (en) begin
      pair_q  <= res;
      flags_q <= nf;
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pair_q) && $stable(flags_q)));

  // R2
  load_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_LD) |=> (pair_q == $past(operand) && flags_q == $past(flags_q)));

  // R10
  half_carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OP_ADD || op == OP_ADC || op == OP_SUB)) |=> flags_q[FH] == $past(flags_q[FH]));

  // R6
  sub_sticky_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_SUB && flags_q[FX]) |=> (flags_q[FX] && flags_q[FN]));

  // R8
  and_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_AND) |=> (flags_q[FH] && !flags_q[FX] && !flags_q[FN] && !flags_q[FC]));

  // R9
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OP_XOR || op == OP_OR)) |=> (flags_q[FH:FX] == 2'b00 && flags_q[FN:FC] == 2'b00));

  // R7
  sbc_keeps_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_SBC) |=> (flags_q[FX] == $past(flags_q[FX]) && flags_q[FN]));
endmodule

// File: tb/pair_alu16_test.sv
module pair_alu16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] operand = 16'h0;
  logic [15:0] pair_q;
  logic [6:0]  flags_q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pair_alu16 uut (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .operand(operand),
                  .pair_q(pair_q), .flags_q(flags_q));

  // {op, operand, expected pair, expected flags {S,Z,H,X,V,N,C}}; chained from reset
  localparam int NV = 26;
  localparam logic [41:0] VEC [NV] = '{
    {3'd7, 16'h7FFF, 16'h7FFF, 7'h00},
    {3'd0, 16'h0001, 16'h8000, 7'h44},
    {3'd0, 16'h8000, 16'h0000, 7'h2D},
    {3'd1, 16'h0000, 16'h0001, 7'h00},
    {3'd0, 16'hFFFF, 16'h0000, 7'h29},
    {3'd1, 16'hFFFF, 16'h0000, 7'h20},
    {3'd2, 16'h0001, 16'hFFFF, 7'h4B},
    {3'd2, 16'h0001, 16'hFFFE, 7'h4A},
    {3'd7, 16'h8000, 16'h8000, 7'h4A},
    {3'd2, 16'h0001, 16'h7FFF, 7'h0E},
    {3'd4, 16'h0000, 16'h0000, 7'h34},
    {3'd6, 16'h8001, 16'h8001, 7'h44},
    {3'd5, 16'h8001, 16'h0000, 7'h24},
    {3'd7, 16'h1000, 16'h1000, 7'h24},
    {3'd3, 16'h0000, 16'h1000, 7'h02},
    {3'd2, 16'h2000, 16'hF000, 7'h4B},
    {3'd3, 16'h0000, 16'hEFFF, 7'h5A},
    {3'd7, 16'h0000, 16'h0000, 7'h5A},
    {3'd2, 16'h0001, 16'hFFFF, 7'h5B},
    {3'd7, 16'h1234, 16'h1234, 7'h5B},
    {3'd3, 16'hFFFF, 16'h1234, 7'h0B},
    {3'd7, 16'h8000, 16'h8000, 7'h0B},
    {3'd3, 16'h7FFF, 16'h0000, 7'h2E},
    {3'd7, 16'h0000, 16'h0000, 7'h2E},
    {3'd3, 16'h0001, 16'hFFFF, 7'h5B},
    {3'd0, 16'h0001, 16'h0000, 7'h39}
  };

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'd0: return "R4/R10";
      3'd1: return "R5/R10";
      3'd2: return "R6/R10";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5, 3'd6: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] ep, logic [6:0] ef);
    checks++;
    if (pair_q !== ep || flags_q !== ef) begin
      errors++;
      $display("FAIL %s: pair=%h flags=%b expected pair=%h flags=%b", tag, pair_q, flags_q, ep, ef);
    end
  endtask

  task automatic step(logic e, logic [2:0] o, logic [15:0] d);
    @(negedge clk);
    en = e; op = o; operand = d;
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 16'h0000, 7'h00);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][41:39], VEC[i][38:23]);
      check(tag_of(VEC[i][41:39]), VEC[i][22:7], VEC[i][6:0]);
    end
    // R3: enable low, several operations attempted, state must not move
    step(1'b0, 3'd0, 16'h1234);
    check("R3", 16'h0000, 7'h39);
    step(1'b0, 3'd7, 16'hABCD);
    check("R3", 16'h0000, 7'h39);
    step(1'b0, 3'd4, 16'h0000);
    check("R3", 16'h0000, 7'h39);
    // R2: load with flags set leaves them intact
    step(1'b1, 3'd7, 16'hABCD);
    check("R2", 16'hABCD, 7'h39);
    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 16'h0000, 7'h00);
    rst_n = 1'b1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule